// File: doc/BRIEF.md
# Flash ready/busy and reset sequencer

This block tracks whether a NOR flash device model may take bus cycles. It sees the device's reset pin (already synchronised to the clock), start and finish strobes from the program/erase engine, an abort request that stands for a read/reset command issued mid-erase or after an error, and a flag that reports the supply is below its write lockout level. From these it drives two outputs. One is an output-enable for an open-drain ready/busy line: 1 pulls the line low, 0 releases it. The other is a ready-for-bus flag that gates the command interface.

A reset pulse counts only once the pin has been low for a minimum number of clock samples. After release, the device stays busy for a fixed wait before it returns to the read state. An abort holds the busy indication for a bounded number of cycles. A supply lockout cancels any operation in progress and shuts the command interface until the supply recovers. All three timing values are parameters counted in clock cycles.

Top module: `flash_rb_seq`

## Requirements
- R1: After the synchronous system reset `rst_n` the block is in the read state: `rb_drive_low`=0 and `bus_ready`=1.
- R2: `op_start` in the read state makes `rb_drive_low`=1 and `bus_ready`=0 from the next cycle. `op_start` has no effect in any other state.
- R3: `op_done` during an operation returns the block to the read state (`rb_drive_low`=0, `bus_ready`=1) on the next cycle.
- R4: A low level on `hw_rst_n` that lasts fewer than MIN_RST_CYC consecutive clock samples leaves the state and both outputs unchanged.
- R5: From the MIN_RST_CYC-th consecutive low sample of `hw_rst_n` on, and for as long as it stays low, `rb_drive_low`=1 and `bus_ready`=0, whatever state the block was in.
- R6: After a qualified reset, `bus_ready` first returns to 1 exactly POST_WAIT_CYC+1 cycles after the first high sample of `hw_rst_n`. `rb_drive_low` stays 1 until then.
- R7: `abort_req` during an operation keeps `rb_drive_low`=1 for ABORT_CYC+1 cycles, counted from the sampling edge, and then returns to the read state. `abort_req` has no effect in the read state.
- R8: `vlock` high in the read, operation or abort state enters lockout on the next cycle: `rb_drive_low`=0, `bus_ready`=0, the operation is cancelled and `op_start` is ignored. The first low sample of `vlock` returns the block to the read state. `vlock` has no effect during a reset hold or the post-reset wait.
- R9: When events coincide, a qualifying reset sample beats lockout, lockout beats `op_done`, and `op_done` beats `abort_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hw_rst_n | input | 1 | Device reset pin, active low, synchronous to clk |
| op_start | input | 1 | Program/erase engine has started an operation |
| op_done | input | 1 | Program/erase engine has finished the operation |
| abort_req | input | 1 | Read/reset command that requires an abort period |
| vlock | input | 1 | Supply is below the write lockout level |
| rb_drive_low | output | 1 | Output-enable for the open-drain ready/busy line; 1 pulls it low |
| bus_ready | output | 1 | Command interface may accept bus cycles |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an engine finish and an abort request, or a finish and a lockout. The second pair is the sample that qualifies a reset and a lockout. The bench provokes each pair by raising both inputs in the same half-cycle. It then judges the pair by the output pair one edge later, which must show the state that R9's priority order selects. Reset pulse widths are swept from one sample to two past the minimum, starting both from idle and from busy. The length of each busy window is counted in cycles and compared against the parameter arithmetic.

// File: rtl/flash_rb_pkg.sv
// Shared types for the ready/busy sequencer.
package flash_rb_pkg;
    // Sequencer states; the busy output is decoded from these.
    typedef enum logic [2:0] {
        ST_READY,   // read state, line released
        ST_BUSY,    // program/erase running
        ST_ABORT,   // bounded abort period
        ST_RHOLD,   // qualified reset, pin still low
        ST_RWAIT,   // post-reset wait
        ST_LOCK     // supply lockout, interface closed
    } rb_state_e;
endpackage

// File: rtl/rst_qualifier.sv
// Counts consecutive low samples of the device reset pin and flags when
// the minimum width has been reached. Assumes hw_rst_n is already
// synchronised to clk and MIN_CYC >= 1.
module rst_qualifier #(
    parameter int MIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_n,
    output logic hit
);
    localparam int W = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
    localparam logic [W-1:0] LAST = W'(MIN_CYC - 1);

    logic [W-1:0] run_q;

    // Saturating run-length of low samples, cleared by any high sample.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (hw_rst_n)     run_q <= '0;
        else if (run_q != LAST) run_q <= run_q + 1'b1;
    end

    // The current sample is the MIN_CYC-th (or a later) low one.
    always_comb hit = !hw_rst_n && (run_q == LAST);
endmodule

// File: rtl/dwell_timer.sv
// Loadable down-counter: a load sets LEN-1 cycles to go; expired is high
// while the count sits at zero. Assumes LEN >= 1.
module dwell_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] START = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= START;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Zero count means the dwell is over.
    always_comb expired = (cnt_q == '0);
endmodule

// File: rtl/flash_rb_seq.sv
// Ready/busy and reset sequencer for a flash device model. Decides from
// reset pin, engine strobes, abort requests and supply lockout whether the
// open-drain busy line is pulled low and whether bus cycles are accepted.
// Assumes all inputs are synchronous to clk; priority is qualified reset,
// then lockout, then op_done, then abort_req.
module flash_rb_seq
    import flash_rb_pkg::*;
#(
    parameter int MIN_RST_CYC   = 8,
    parameter int POST_WAIT_CYC = 20,
    parameter int ABORT_CYC     = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_n,
    input  logic op_start,
    input  logic op_done,
    input  logic abort_req,
    input  logic vlock,
    output logic rb_drive_low,
    output logic bus_ready
);
    rb_state_e state, nxt;
    logic rst_hit, ld_post, ld_abort, post_exp, abort_exp;

    rst_qualifier #(.MIN_CYC(MIN_RST_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .hit(rst_hit)
    );

    dwell_timer #(.LEN(POST_WAIT_CYC)) u_post (
        .clk(clk), .rst_n(rst_n), .load(ld_post), .expired(post_exp)
    );

    dwell_timer #(.LEN(ABORT_CYC)) u_abort (
        .clk(clk), .rst_n(rst_n), .load(ld_abort), .expired(abort_exp)
    );

    // Next-state selection in priority order.
    always_comb begin
        nxt      = state;
        ld_post  = 1'b0;
        ld_abort = 1'b0;
        if (rst_hit) begin
            nxt = ST_RHOLD;
        end else if (state == ST_RHOLD) begin
            if (hw_rst_n) begin
                nxt     = ST_RWAIT;
                ld_post = 1'b1;
            end
        end else if (state == ST_RWAIT) begin
            if (post_exp) nxt = ST_READY;
        end else if (vlock) begin
            nxt = ST_LOCK;
        end else begin
            case (state)
                ST_READY: if (op_start) nxt = ST_BUSY;
                ST_BUSY: begin
                    if (op_done) begin
                        nxt = ST_READY;
                    end else if (abort_req) begin
                        nxt      = ST_ABORT;
                        ld_abort = 1'b1;
                    end
                end
                ST_ABORT: if (abort_exp) nxt = ST_READY;
                default:  nxt = ST_READY;
            endcase
        end
    end

    // State register with synchronous system reset to the read state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nxt;
    end

    // Output decode from the registered state.
    always_comb begin
        rb_drive_low = (state == ST_BUSY) || (state == ST_ABORT) ||
                       (state == ST_RHOLD) || (state == ST_RWAIT);
        bus_ready    = (state == ST_READY);
    end
endmodule

// File: rtl/flash_rb_chk.sv
// Property checker for flash_rb_seq, attached by bind. Keeps its own run
// counters so that parameter-sized windows are not unrolled.
module flash_rb_chk
    import flash_rb_pkg::*;
#(
    parameter int MIN_RST_CYC   = 8,
    parameter int POST_WAIT_CYC = 20,
    parameter int ABORT_CYC     = 40
) (
    input logic      clk,
    input logic      rst_n,
    input logic      hw_rst_n,
    input logic      op_start,
    input logic      op_done,
    input logic      abort_req,
    input logic      vlock,
    input logic      rb_drive_low,
    input logic      bus_ready,
    input rb_state_e state
);
    int low_run;
    int ab_run;

    // Consecutive low samples of the reset pin before this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst_n)          low_run <= 0;
        else if (low_run < MIN_RST_CYC)  low_run <= low_run + 1;
    end

    // Consecutive cycles already spent in the abort state.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_ABORT)     ab_run <= 0;
        else if (ab_run <= ABORT_CYC)        ab_run <= ab_run + 1;
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && op_start && !vlock && hw_rst_n)
        |=> (rb_drive_low && !bus_ready));

    // R3 and R9: a finish wins over a simultaneous abort request.
    a_r3_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && op_done && !vlock && hw_rst_n)
        |=> bus_ready);

    a_r4_short_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RHOLD && (hw_rst_n || low_run < MIN_RST_CYC - 1))
        |=> (state != ST_RHOLD));

    a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_n && low_run >= MIN_RST_CYC - 1)
        |=> (rb_drive_low && !bus_ready));

    a_r7_abort_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT) |-> (ab_run < ABORT_CYC));

    a_r8_lock_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && vlock && hw_rst_n)
        |=> (!rb_drive_low && !bus_ready));

    a_r8_abort_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && abort_req && !op_start && !vlock && hw_rst_n)
        |=> bus_ready);
endmodule

bind flash_rb_seq flash_rb_chk #(
    .MIN_RST_CYC(MIN_RST_CYC),
    .POST_WAIT_CYC(POST_WAIT_CYC),
    .ABORT_CYC(ABORT_CYC)
) i_chk (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .op_start(op_start),
    .op_done(op_done), .abort_req(abort_req), .vlock(vlock),
    .rb_drive_low(rb_drive_low), .bus_ready(bus_ready), .state(state)
);

// File: tb/test_flash_rb_seq.sv
// Self-checking bench: sweeps reset pulse widths, measures busy windows
// and provokes coinciding events. Inputs change on the falling edge.
module test_flash_rb_seq;
    localparam int MIN_C  = 4;
    localparam int POST_C = 6;
    localparam int ABT_C  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0, hw_rst_n = 1'b1, op_start = 1'b0, op_done = 1'b0;
    logic abort_req = 1'b0, vlock = 1'b0;
    logic rb_drive_low, bus_ready;
    int   n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    flash_rb_seq #(.MIN_RST_CYC(MIN_C), .POST_WAIT_CYC(POST_C), .ABORT_CYC(ABT_C))
    i_flash_rb_seq (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .op_start(op_start),
        .op_done(op_done), .abort_req(abort_req), .vlock(vlock),
        .rb_drive_low(rb_drive_low), .bus_ready(bus_ready)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp_rb, input logic exp_rdy);
        n_chk++;
        if (rb_drive_low !== exp_rb || bus_ready !== exp_rdy) begin
            n_bad++;
            $display("FAIL %s: rb/ready = %b/%b, expected %b/%b",
                     req, rb_drive_low, bus_ready, exp_rb, exp_rdy);
        end
    endtask

    task automatic chk_n(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", req, got, exp);
        end
    endtask

    // Steps until bus_ready; reports the count and whether busy held throughout.
    task automatic wait_ready(output int n, output bit held);
        n = 0;
        held = 1'b1;
        do begin
            step();
            n++;
            if (!bus_ready && !rb_drive_low) held = 1'b0;
        end while (!bus_ready && n < 200);
    endtask

    task automatic go_busy();
        op_start = 1'b1; step(); op_start = 1'b0;
        chk("R2 start", 1'b1, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        int  n;
        bit  held;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 reset state", 1'b0, 1'b1);

        go_busy();
        op_start = 1'b1; step(); op_start = 1'b0;
        chk("R2 start ignored while busy", 1'b1, 1'b0);
        op_done = 1'b1; step(); op_done = 1'b0;
        chk("R3 done", 1'b0, 1'b1);

        // R4/R5/R6: reset width sweep from idle and from busy.
        for (int w = 1; w <= MIN_C + 2; w++) begin
            for (int fb = 0; fb < 2; fb++) begin
                if (fb == 1) go_busy();
                hw_rst_n = 1'b0;
                for (int i = 1; i <= w; i++) begin
                    step();
                    if (i >= MIN_C)       chk("R5 reset hold", 1'b1, 1'b0);
                    else if (fb == 1)     chk("R4 short pulse busy", 1'b1, 1'b0);
                    else                  chk("R4 short pulse idle", 1'b0, 1'b1);
                end
                hw_rst_n = 1'b1;
                if (w >= MIN_C) begin
                    wait_ready(n, held);
                    chk_n("R6 post-reset wait length", n, POST_C + 1);
                    chk_n("R6 busy held through wait", int'(held), 1);
                end else begin
                    step();
                    if (fb == 1) begin
                        chk("R4 still busy after short pulse", 1'b1, 1'b0);
                        op_done = 1'b1; step(); op_done = 1'b0;
                        chk("R4 R3 done after short pulse", 1'b0, 1'b1);
                    end else begin
                        chk("R4 still idle after short pulse", 1'b0, 1'b1);
                    end
                end
            end
        end

        // R7: abort window, and abort in the read state.
        abort_req = 1'b1; step(); abort_req = 1'b0;
        chk("R7 abort ignored when idle", 1'b0, 1'b1);
        go_busy();
        abort_req = 1'b1;
        wait_ready(n, held);
        abort_req = 1'b0;
        chk_n("R7 abort window length", n, ABT_C + 1);
        chk_n("R7 busy held through abort", int'(held), 1);

        // R8: lockout from busy, start ignored, exit to read.
        go_busy();
        vlock = 1'b1; step();
        chk("R8 lockout cancels op", 1'b0, 1'b0);
        op_start = 1'b1; step(); op_start = 1'b0;
        chk("R8 start ignored in lockout", 1'b0, 1'b0);
        vlock = 1'b0; step();
        chk("R8 lockout exit", 1'b0, 1'b1);
        // R8: lockout from abort and from read.
        go_busy();
        abort_req = 1'b1; step(); abort_req = 1'b0;
        vlock = 1'b1; step();
        chk("R8 lockout cancels abort", 1'b0, 1'b0);
        vlock = 1'b0; step();
        vlock = 1'b1; step();
        chk("R8 lockout from read", 1'b0, 1'b0);
        vlock = 1'b0; step();

        // R9: done and abort together.
        go_busy();
        op_done = 1'b1; abort_req = 1'b1; step();
        op_done = 1'b0; abort_req = 1'b0;
        chk("R9 done beats abort", 1'b0, 1'b1);
        // R9: lockout and done together.
        go_busy();
        vlock = 1'b1; op_done = 1'b1; step();
        vlock = 1'b0; op_done = 1'b0;
        chk("R9 lockout beats done", 1'b0, 1'b0);
        step();
        chk("R9 read after lockout", 1'b0, 1'b1);
        // R9: qualifying reset sample and lockout together; R8 lock ignored in hold.
        hw_rst_n = 1'b0;
        for (int i = 1; i < MIN_C; i++) step();
        chk("R4 idle before qualifying sample", 1'b0, 1'b1);
        vlock = 1'b1; step();
        chk("R9 reset beats lockout", 1'b1, 1'b0);
        step();
        chk("R8 lockout ignored in reset hold", 1'b1, 1'b0);
        vlock = 1'b0; hw_rst_n = 1'b1;
        wait_ready(n, held);
        chk_n("R6 wait after coincident reset", n, POST_C + 1);

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end
endmodule